// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Access Checking

This block is a small, fully associative cache of page translations that sits in front of any table walk. Every load, store and instruction fetch presents its virtual address, its access kind, its privilege mode and the current context identifier. One clock later the block answers with one of three outcomes:

- **hit**, with the physical address;
- **miss**, meaning no usable mapping is held;
- **fault**, meaning a mapping exists but forbids this access.

Each entry pairs a virtual page number with a physical page number. It carries read, write and execute rights, a bit that opens the page to user mode, and a global bit. Entries are tagged with the context identifier of the address space that owns them, so a context switch needs no flush.

An external walker installs translations through the fill port. The victim slot is chosen by the block itself: it takes the lowest-numbered empty slot first, and otherwise follows a round-robin pointer. Two invalidation commands exist. One clears every entry. The other clears only the non-global entries that belong to one context.

Top module: `ctx_tlb`

## Requirements
- R1: One cycle after `lookup_valid_i` is high, `res_valid_o` is high with exactly one of `res_hit_o`, `res_miss_o`, `res_fault_o` high. In a cycle following no lookup, all four are low.
- R2: A lookup matches an entry only when all three of these hold:
  - the entry is valid;
  - its page number equals address bits [47:12];
  - its context equals `cur_ctx_i`, or the entry is global.
  
  With no match the outcome is miss.
- R3: On a hit, `res_paddr_o` is the stored physical page number in bits [47:12], followed by the lookup's 12-bit page offset. When the outcome is not a hit, `res_paddr_o` is zero.
- R4: Access code 0 (read) needs the read right. Code 1 (write) needs the write right. Code 2 (execute) needs the execute right. A matching entry without the needed right gives fault. Code 3 always gives fault on a match.
- R5: A lookup with `lookup_user_i` high on a matching entry whose user bit is clear gives fault. A lookup with `lookup_user_i` low ignores the user bit.
- R6: A global entry matches under any `cur_ctx_i`.
- R7: An accepted fill writes the lowest-indexed invalid entry if any entry is invalid. Otherwise it writes the entry under the round-robin pointer. The pointer resets to entry 0 and advances by one, wrapping after the last entry, on each fill made while no entry was invalid.
- R8: `flush_all_i` invalidates every entry at the next edge, so a lookup issued in the following cycle misses.
- R9: `flush_ctx_i` invalidates exactly the valid, non-global entries whose context equals `flush_ctx_id_i`. Every other entry stays usable.
- R10: A fill presented in the same cycle as `flush_all_i` or `flush_ctx_i` is dropped and installs nothing.
- R11: After reset all entries are invalid, all result outputs are zero and the round-robin pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vaddr_i | input | 48 | Virtual address (page number [47:12], offset [11:0]) |
| lookup_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lookup_user_i | input | 1 | Request comes from user mode |
| cur_ctx_i | input | 12 | Current context identifier |
| res_valid_o | output | 1 | Result present |
| res_hit_o | output | 1 | Translation granted |
| res_miss_o | output | 1 | No matching entry |
| res_fault_o | output | 1 | Entry present, access refused |
| res_paddr_o | output | 48 | Physical address on hit, else zero |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 36 | Virtual page number to install |
| fill_ppn_i | input | 36 | Physical page number to install |
| fill_ctx_i | input | 12 | Owning context |
| fill_global_i | input | 1 | Entry matches every context |
| fill_user_i | input | 1 | Entry usable from user mode |
| fill_read_i | input | 1 | Read right |
| fill_write_i | input | 1 | Write right |
| fill_exec_i | input | 1 | Execute right |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_ctx_i | input | 1 | Invalidate non-global entries of one context |
| flush_ctx_id_i | input | 12 | Context to invalidate |

## Verification
The assertions check on every cycle the properties that do not depend on stored contents:

- the one-cycle latency and the single-outcome encoding of the result;
- a zero address on any non-hit;
- the empty table after a full flush;
- no entry becoming valid while a flush is present.

Only the bench's scenarios can show behaviour that depends on what is stored:

- which entry a fill evicts, under round-robin and invalid-first selection;
- that flushing a context spares global entries and other contexts;
- the permission and user-mode decisions for each access kind;
- the exact physical address returned.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic glb;
    logic usr;
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  function automatic logic perm_ok(perm_t p, acc_e acc, logic user_mode);
    logic right;
    case (acc)
      ACC_READ:  right = p.rd;
      ACC_WRITE: right = p.wr;
      ACC_EXEC:  right = p.ex;
      default:   right = 1'b0;
    endcase
    return right && (!user_mode || p.usr);
  endfunction

endpackage

// File: rtl/ctx_tlb_store.sv
module ctx_tlb_store
  import ctx_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned VPN_W     = 36,
  parameter int unsigned PPN_W     = 36,
  parameter int unsigned CTX_W     = 12,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [VPN_W-1:0]                wr_vpn_i,
  input  logic [PPN_W-1:0]                wr_ppn_i,
  input  logic [CTX_W-1:0]                wr_ctx_i,
  input  perm_t                           wr_perm_i,
  input  logic                            flush_all_i,
  input  logic                            flush_ctx_i,
  input  logic [CTX_W-1:0]                flush_ctx_id_i,
  output logic [N_ENTRIES-1:0]            valid_o,
  output logic [N_ENTRIES-1:0][VPN_W-1:0] vpn_o,
  output logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_o,
  output logic [N_ENTRIES-1:0][CTX_W-1:0] ctx_o,
  output perm_t [N_ENTRIES-1:0]           perm_o
);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    logic sel;
    logic ctx_kill;

    assign sel      = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign ctx_kill = flush_ctx_i && !perm_o[i].glb && (ctx_o[i] == flush_ctx_id_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
      end else if (flush_all_i || ctx_kill) begin
        valid_o[i] <= 1'b0;
      end else if (sel) begin
        valid_o[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_o[i]  <= '0;
        ppn_o[i]  <= '0;
        ctx_o[i]  <= '0;
        perm_o[i] <= '0;
      end else if (sel) begin
        vpn_o[i]  <= wr_vpn_i;
        ppn_o[i]  <= wr_ppn_i;
        ctx_o[i]  <= wr_ctx_i;
        perm_o[i] <= wr_perm_i;
      end
    end
  end

endmodule

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
  import ctx_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned VPN_W     = 36,
  parameter int unsigned PPN_W     = 36,
  parameter int unsigned CTX_W     = 12
) (
  input  logic [N_ENTRIES-1:0]            valid_i,
  input  logic [N_ENTRIES-1:0][VPN_W-1:0] vpn_i,
  input  logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_i,
  input  logic [N_ENTRIES-1:0][CTX_W-1:0] ctx_i,
  input  perm_t [N_ENTRIES-1:0]           perm_i,
  input  logic [VPN_W-1:0]                lk_vpn_i,
  input  logic [CTX_W-1:0]                lk_ctx_i,
  output logic                            hit_o,
  output logic [PPN_W-1:0]                ppn_o,
  output perm_t                           perm_o
);

  logic [N_ENTRIES-1:0] match;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign match[i] = valid_i[i] && (vpn_i[i] == lk_vpn_i) &&
                      (perm_i[i].glb || (ctx_i[i] == lk_ctx_i));
  end

  // AND-OR select; fills never install a duplicate tag
  always_comb begin
    hit_o  = |match;
    ppn_o  = '0;
    perm_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (match[i]) begin
        ppn_o  = ppn_o | ppn_i[i];
        perm_o = perm_t'(perm_o | perm_i[i]);
      end
    end
  end

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
  parameter int unsigned N_ENTRIES = 8,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic                 fill_i,
  output logic [IDX_W-1:0]     idx_o
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             has_free;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign idx_o = has_free ? free_idx : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (fill_i && !has_free) begin
      ptr_q <= (ptr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned VPN_W     = 36,
  parameter int unsigned PPN_W     = 36,
  parameter int unsigned CTX_W     = 12,
  parameter int unsigned OFF_W     = 12,
  localparam int unsigned VA_W     = VPN_W + OFF_W,
  localparam int unsigned PA_W     = PPN_W + OFF_W,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [VA_W-1:0]  lookup_vaddr_i,
  input  logic [1:0]       lookup_acc_i,
  input  logic             lookup_user_i,
  input  logic [CTX_W-1:0] cur_ctx_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic             res_miss_o,
  output logic             res_fault_o,
  output logic [PA_W-1:0]  res_paddr_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [CTX_W-1:0] fill_ctx_i,
  input  logic             fill_global_i,
  input  logic             fill_user_i,
  input  logic             fill_read_i,
  input  logic             fill_write_i,
  input  logic             fill_exec_i,
  input  logic             flush_all_i,
  input  logic             flush_ctx_i,
  input  logic [CTX_W-1:0] flush_ctx_id_i
);

  logic [N_ENTRIES-1:0]            entry_valid;
  logic [N_ENTRIES-1:0][VPN_W-1:0] entry_vpn;
  logic [N_ENTRIES-1:0][PPN_W-1:0] entry_ppn;
  logic [N_ENTRIES-1:0][CTX_W-1:0] entry_ctx;
  perm_t [N_ENTRIES-1:0]           entry_perm;

  logic             fill_accept;
  logic [IDX_W-1:0] victim_idx;
  perm_t            fill_perm;

  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  perm_t            lk_perm;
  logic             lk_ok;

  // flushes win over a same-cycle fill
  assign fill_accept = fill_valid_i && !flush_all_i && !flush_ctx_i;

  assign fill_perm = '{glb: fill_global_i, usr: fill_user_i, rd: fill_read_i,
                       wr: fill_write_i, ex: fill_exec_i};

  ctx_tlb_victim #(.N_ENTRIES(N_ENTRIES)) i_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (entry_valid),
    .fill_i  (fill_accept),
    .idx_o   (victim_idx)
  );

  ctx_tlb_store #(
    .N_ENTRIES (N_ENTRIES),
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W),
    .CTX_W     (CTX_W)
  ) i_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (fill_accept),
    .wr_idx_i       (victim_idx),
    .wr_vpn_i       (fill_vpn_i),
    .wr_ppn_i       (fill_ppn_i),
    .wr_ctx_i       (fill_ctx_i),
    .wr_perm_i      (fill_perm),
    .flush_all_i    (flush_all_i),
    .flush_ctx_i    (flush_ctx_i),
    .flush_ctx_id_i (flush_ctx_id_i),
    .valid_o        (entry_valid),
    .vpn_o          (entry_vpn),
    .ppn_o          (entry_ppn),
    .ctx_o          (entry_ctx),
    .perm_o         (entry_perm)
  );

  ctx_tlb_match #(
    .N_ENTRIES (N_ENTRIES),
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W),
    .CTX_W     (CTX_W)
  ) i_match (
    .valid_i  (entry_valid),
    .vpn_i    (entry_vpn),
    .ppn_i    (entry_ppn),
    .ctx_i    (entry_ctx),
    .perm_i   (entry_perm),
    .lk_vpn_i (lookup_vaddr_i[VA_W-1:OFF_W]),
    .lk_ctx_i (cur_ctx_i),
    .hit_o    (lk_hit),
    .ppn_o    (lk_ppn),
    .perm_o   (lk_perm)
  );

  assign lk_ok = perm_ok(lk_perm, acc_e'(lookup_acc_i), lookup_user_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_miss_o  <= 1'b0;
      res_fault_o <= 1'b0;
      res_paddr_o <= '0;
    end else begin
      res_valid_o <= lookup_valid_i;
      res_hit_o   <= lookup_valid_i && lk_hit && lk_ok;
      res_miss_o  <= lookup_valid_i && !lk_hit;
      res_fault_o <= lookup_valid_i && lk_hit && !lk_ok;
      res_paddr_o <= (lookup_valid_i && lk_hit && lk_ok) ?
                     {lk_ppn, lookup_vaddr_i[OFF_W-1:0]} : '0;
    end
  end

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned PA_W      = 48
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lookup_valid_i,
  input logic                 res_valid_o,
  input logic                 res_hit_o,
  input logic                 res_miss_o,
  input logic                 res_fault_o,
  input logic [PA_W-1:0]      res_paddr_o,
  input logic                 flush_all_i,
  input logic                 flush_ctx_i,
  input logic [N_ENTRIES-1:0] entry_valid
);

  a_r1_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $onehot({res_hit_o, res_miss_o, res_fault_o}));

  a_r1_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !(res_hit_o || res_miss_o || res_fault_o));

  a_r1_one_cycle_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> res_valid_o);

  a_r3_paddr_zero_unless_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> (res_paddr_o == '0));

  a_r8_flush_all_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (entry_valid == '0));

  a_r10_no_fill_under_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i || flush_ctx_i) |=> ((entry_valid & ~$past(entry_valid)) == '0));

endmodule

bind ctx_tlb ctx_tlb_chk #(.N_ENTRIES(N_ENTRIES), .PA_W(PA_W)) i_ctx_tlb_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .res_valid_o    (res_valid_o),
  .res_hit_o      (res_hit_o),
  .res_miss_o     (res_miss_o),
  .res_fault_o    (res_fault_o),
  .res_paddr_o    (res_paddr_o),
  .flush_all_i    (flush_all_i),
  .flush_ctx_i    (flush_ctx_i),
  .entry_valid    (entry_valid)
);

// File: tb/test_ctx_tlb.sv
`timescale 1ns/1ps
module test_ctx_tlb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [47:0] lookup_vaddr_i = '0;
  logic [1:0]  lookup_acc_i = '0;
  logic        lookup_user_i = 1'b0;
  logic [11:0] cur_ctx_i = '0;
  logic        res_valid_o, res_hit_o, res_miss_o, res_fault_o;
  logic [47:0] res_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [35:0] fill_vpn_i = '0;
  logic [35:0] fill_ppn_i = '0;
  logic [11:0] fill_ctx_i = '0;
  logic        fill_global_i = 1'b0, fill_user_i = 1'b0;
  logic        fill_read_i = 1'b0, fill_write_i = 1'b0, fill_exec_i = 1'b0;
  logic        flush_all_i = 1'b0, flush_ctx_i = 1'b0;
  logic [11:0] flush_ctx_id_i = '0;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2, RS = 2'd3;
  localparam int OUT_HIT = 1, OUT_MISS = 2, OUT_FAULT = 3;

  always #2.5 clk_i = ~clk_i;

  ctx_tlb i_ctx_tlb (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [35:0] ppn, input logic [11:0] ctx,
                      input logic glb, input logic usr, input logic r, input logic w,
                      input logic x);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_ctx_i = ctx;
    fill_global_i = glb; fill_user_i = usr;
    fill_read_i = r; fill_write_i = w; fill_exec_i = x;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic flush(input logic all, input logic byctx, input logic [11:0] id);
    @(negedge clk_i);
    flush_all_i = all; flush_ctx_i = byctx; flush_ctx_id_i = id;
    @(negedge clk_i);
    flush_all_i = 1'b0; flush_ctx_i = 1'b0;
  endtask

  // issue one lookup; result is registered, so sample at the following negedge
  task automatic look(input string req, input logic [35:0] vpn, input logic [11:0] off,
                      input logic [1:0] acc, input logic usr, input logic [11:0] ctx,
                      input int outcome, input logic [35:0] ppn);
    logic [47:0] exp_pa;
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_vaddr_i = {vpn, off};
    lookup_acc_i = acc; lookup_user_i = usr; cur_ctx_i = ctx;
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
    exp_pa = (outcome == OUT_HIT) ? {ppn, off} : 48'h0;
    chk({req, " outcome"}, {60'h0, res_valid_o, res_hit_o, res_miss_o, res_fault_o},
        {60'h0, 1'b1, outcome == OUT_HIT, outcome == OUT_MISS, outcome == OUT_FAULT});
    chk({req, " paddr"}, {16'h0, res_paddr_o}, {16'h0, exp_pa});
  endtask

  task automatic t_reset;
    chk("R11 reset outputs", {59'h0, res_valid_o, res_hit_o, res_miss_o, res_fault_o, |res_paddr_o},
        64'h0);
    look("R11 empty after reset", 36'h12345, 12'h0, RD, 1'b0, 12'h5, OUT_MISS, '0);
    @(negedge clk_i);
    chk("R1 idle after lookup", {63'h0, res_valid_o}, 64'h0);
  endtask

  task automatic t_hit;
    fill(36'h12345, 36'hABCDE, 12'h5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    look("R3 hit paddr", 36'h12345, 12'h3C4, RD, 1'b1, 12'h5, OUT_HIT, 36'hABCDE);
    look("R2 other vpn misses", 36'h12346, 12'h0, RD, 1'b1, 12'h5, OUT_MISS, '0);
  endtask

  task automatic t_perm;
    fill(36'h00A00, 36'h0A0A0, 12'h5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    look("R4 read allowed", 36'h00A00, 12'h010, RD, 1'b1, 12'h5, OUT_HIT, 36'h0A0A0);
    look("R4 write denied", 36'h00A00, 12'h010, WR, 1'b1, 12'h5, OUT_FAULT, '0);
    look("R4 exec denied", 36'h00A00, 12'h010, EX, 1'b1, 12'h5, OUT_FAULT, '0);
    look("R4 reserved code", 36'h00A00, 12'h010, RS, 1'b0, 12'h5, OUT_FAULT, '0);
    fill(36'h00B00, 36'h0B0B0, 12'h5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    look("R5 user on kernel page", 36'h00B00, 12'h020, RD, 1'b1, 12'h5, OUT_FAULT, '0);
    look("R5 supervisor on kernel page", 36'h00B00, 12'h020, WR, 1'b0, 12'h5, OUT_HIT,
         36'h0B0B0);
  endtask

  task automatic t_ctx;
    look("R2 foreign context misses", 36'h12345, 12'h0, RD, 1'b1, 12'h6, OUT_MISS, '0);
    fill(36'h00C00, 36'h0C0C0, 12'h5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    look("R6 global any context", 36'h00C00, 12'h7FF, EX, 1'b1, 12'h9, OUT_HIT, 36'h0C0C0);
  endtask

  task automatic t_flush_ctx;
    fill(36'h00D00, 36'h0D0D0, 12'h7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    flush(1'b0, 1'b1, 12'h5);
    look("R9 owned entry cleared", 36'h12345, 12'h0, RD, 1'b0, 12'h5, OUT_MISS, '0);
    look("R9 second owned entry cleared", 36'h00A00, 12'h0, RD, 1'b0, 12'h5, OUT_MISS, '0);
    look("R9 global kept", 36'h00C00, 12'h004, RD, 1'b0, 12'h5, OUT_HIT, 36'h0C0C0);
    look("R9 other context kept", 36'h00D00, 12'h008, RD, 1'b0, 12'h7, OUT_HIT, 36'h0D0D0);
  endtask

  task automatic t_flush_all;
    flush(1'b1, 1'b0, 12'h0);
    look("R8 global gone", 36'h00C00, 12'h0, RD, 1'b0, 12'h5, OUT_MISS, '0);
    look("R8 entry gone", 36'h00D00, 12'h0, RD, 1'b0, 12'h7, OUT_MISS, '0);
  endtask

  task automatic t_drop;
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 36'h00E00; fill_ppn_i = 36'h0E0E0; fill_ctx_i = 12'h3;
    fill_global_i = 1'b0; fill_user_i = 1'b1;
    fill_read_i = 1'b1; fill_write_i = 1'b1; fill_exec_i = 1'b1;
    flush_ctx_i = 1'b1; flush_ctx_id_i = 12'hFFF;
    @(negedge clk_i);
    flush_ctx_i = 1'b0; flush_all_i = 1'b1;
    @(negedge clk_i);
    fill_valid_i = 1'b0; flush_all_i = 1'b0;
    look("R10 fill dropped", 36'h00E00, 12'h0, RD, 1'b0, 12'h3, OUT_MISS, '0);
  endtask

  task automatic t_round_robin;
    for (int i = 0; i < 8; i++)
      fill(36'h100 + 36'(i), 36'h9000 + 36'(i), 12'h10 + 12'(i), 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++)
      look("R7 table full hit", 36'h100 + 36'(i), 12'h0, RD, 1'b1, 12'h10 + 12'(i), OUT_HIT,
           36'h9000 + 36'(i));
    fill(36'h200, 36'h8200, 12'h30, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    look("R7 pointer starts at entry 0", 36'h100, 12'h0, RD, 1'b1, 12'h10, OUT_MISS, '0);
    look("R7 entry 1 kept", 36'h101, 12'h0, RD, 1'b1, 12'h11, OUT_HIT, 36'h9001);
    fill(36'h201, 36'h8201, 12'h30, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    look("R7 pointer advanced", 36'h101, 12'h0, RD, 1'b1, 12'h11, OUT_MISS, '0);
    flush(1'b0, 1'b1, 12'h15);
    fill(36'h202, 36'h8202, 12'h30, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    look("R7 invalid slot first", 36'h102, 12'h0, RD, 1'b1, 12'h12, OUT_HIT, 36'h9002);
    look("R7 new entry present", 36'h202, 12'h0, RD, 1'b1, 12'h30, OUT_HIT, 36'h8202);
    fill(36'h203, 36'h8203, 12'h30, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    look("R7 pointer resumes", 36'h102, 12'h0, RD, 1'b1, 12'h12, OUT_MISS, '0);
    look("R7 entry 3 kept", 36'h103, 12'h0, RD, 1'b1, 12'h13, OUT_HIT, 36'h9003);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_hit();
        t_perm();
        t_ctx();
        t_flush_ctx();
        t_flush_all();
        t_drop();
        t_round_robin();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule